// File: doc/BRIEF.md
# Compare and Increment Execution Unit

This unit carries out two groups of 8-bit instructions for a small accumulator processor: compare against the accumulator, and increment by one. It holds the accumulator A, six general registers (B, C, D, E, H, L) and four flag bits. The flag bits are zero (Z), subtract (N), half-carry (H) and carry (C). A compare computes the flags of A minus an operand and discards the difference. An increment adds one to a register, or to the byte in memory at the address H:L. An increment leaves the carry flag as it was.

An instruction starts with a one-cycle `start_i` pulse while the unit is idle. The pulse carries the opcode, and also the immediate byte for the compare-immediate form. The unit stays busy for the cycle cost of that opcode. It raises `done_o` for one clock in its last busy cycle, and results are visible from the following cycle.

Memory traffic uses a valid/ready pair. While `mem_req_o` is high, the address, the write enable and the write data are held unchanged. A transfer completes in any cycle where `mem_ready_i` is also high, and read data is taken in that same cycle. Every cycle with the request high and ready low stretches the instruction by one clock.

A side load port lets the surrounding datapath preset registers while the unit is idle. All registers and flags are visible on `regs_o` and `flags_o`.

Top module: `cpinc_unit`

## Requirements
- R1: Opcodes 0xB8..0xBF compare A with the operand selected by opcode bits [2:0]. The selection codes are 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=byte at {H,L}, 7=A. A compare never changes A or any other register.
- R2: A compare sets Z when (A − operand) mod 256 is 0 and sets N to 1. It sets H when A[3:0] < operand[3:0], and sets C when A < operand as unsigned values. Comparing A with itself gives Z=1, N=1, H=0, C=0.
- R3: Opcode 0xFE compares A with `imm_i`, which is sampled in the cycle in which start is accepted.
- R4: Opcodes with bits [7:6]=00 and [2:0]=100 increment the target selected by bits [5:3], using the same codes as R1. The result wraps modulo 256.
- R5: An increment sets N=0. It sets H when the old low nibble was 0xF, sets Z when the wrapped result is 0, and leaves C unchanged.
- R6: With memory always ready, busy lasts 4 cycles for register forms, 8 cycles for compare with {H,L} and compare-immediate, and 12 cycles for increment of {H,L}. `done_o` is high for exactly the last busy cycle.
- R7: Compare with {H,L} issues exactly one read at address {H,L}. Increment of {H,L} reads at that address, then writes the incremented byte to the same address. The write request appears only after the read has completed.
- R8: While `mem_req_o` is high and `mem_ready_i` is low, address, write enable and write data stay stable. Each such stall cycle adds one cycle to the instruction.
- R9: An opcode outside both groups raises `illegal_o` for one cycle, starting in the cycle after acceptance. It changes no register or flag, and it produces no busy state and no done.
- R10: A start pulse while busy is ignored and does not alter the running instruction.
- R11: After reset all registers and flags read 0, the unit is idle, and no memory request is raised.
- R12: The load port writes `ld_data_i` into the register selected by `ld_sel_i` (codes as in R1) only while idle. Code 6 has no effect, and `regs_o` byte 6 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| opcode_i | input | 8 | Opcode sampled with start |
| imm_i | input | DW | Immediate byte sampled with start |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle pulse in the last busy cycle |
| illegal_o | output | 1 | One-cycle pulse for an unsupported opcode |
| ld_en_i | input | 1 | Register preload enable (idle only) |
| ld_sel_i | input | 3 | Preload register code |
| ld_data_i | input | DW | Preload value |
| regs_o | output | 8*DW | Register bytes, byte k holds register code k |
| flags_o | output | 4 | {Z, N, H, C} |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 2*DW | Address {H, L} |
| mem_wdata_o | output | DW | Write data |
| mem_ready_i | input | 1 | Memory accepts or returns data this cycle |
| mem_rdata_i | input | DW | Read data, valid with ready on a read |

## Verification
The assertions check, on every cycle, that memory requests hold steady under back-pressure and that done never lasts two cycles. They also check that a busy unit stays busy until done, that an illegal pulse never coincides with busy or done, that compare leaves A untouched, that increment keeps carry, and that no compare issues a write. Only the bench's scenarios show the rest. That covers the flag values against independently computed results, the exact cycle counts with and without stalls, the order of read and write and the value written back, the nibble and wrap boundaries, and the fact that start pulses during busy and illegal opcodes leave the state unchanged.

// File: rtl/cpinc_pkg.sv
package cpinc_pkg;
  typedef enum logic [1:0] {SRC_REG, SRC_MEM, SRC_IMM} src_t;
  typedef enum logic [1:0] {PH_NONE, PH_RD, PH_WR} phase_t;
  typedef enum logic [1:0] {COST_ONE, COST_TWO, COST_THREE} cost_t;

  localparam logic [2:0] SEL_H   = 3'd4;
  localparam logic [2:0] SEL_L   = 3'd5;
  localparam logic [2:0] SEL_MEM = 3'd6;
  localparam logic [2:0] SEL_A   = 3'd7;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;

  typedef struct packed {
    logic       legal;
    logic       is_cp;
    src_t       src;
    logic [2:0] sel;
    cost_t      cost;
  } dec_t;
endpackage

// File: rtl/cpinc_decode.sv
module cpinc_decode
  import cpinc_pkg::*;
(
  input  logic [7:0] op_i,
  output dec_t       dec_o
);
  localparam logic [4:0] CP_HI  = 5'b10111;
  localparam logic [7:0] CP_IMM = 8'hFE;
  localparam logic [2:0] INC_LO = 3'b100;

  always_comb begin
    dec_o = '{legal: 1'b0, is_cp: 1'b0, src: SRC_REG, sel: SEL_A, cost: COST_ONE};
    if (op_i[7:3] == CP_HI) begin
      dec_o.legal = 1'b1;
      dec_o.is_cp = 1'b1;
      dec_o.sel   = op_i[2:0];
      dec_o.src   = (op_i[2:0] == SEL_MEM) ? SRC_MEM : SRC_REG;
      dec_o.cost  = (op_i[2:0] == SEL_MEM) ? COST_TWO : COST_ONE;
    end else if (op_i == CP_IMM) begin
      dec_o.legal = 1'b1;
      dec_o.is_cp = 1'b1;
      dec_o.src   = SRC_IMM;
      dec_o.cost  = COST_TWO;
    end else if (op_i[7:6] == 2'b00 && op_i[2:0] == INC_LO) begin
      dec_o.legal = 1'b1;
      dec_o.sel   = op_i[5:3];
      dec_o.src   = (op_i[5:3] == SEL_MEM) ? SRC_MEM : SRC_REG;
      dec_o.cost  = (op_i[5:3] == SEL_MEM) ? COST_THREE : COST_ONE;
    end
  end
endmodule

// File: rtl/cpinc_alu.sv
module cpinc_alu
  import cpinc_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          is_cp_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] opnd_i,
  input  flags_t        flags_i,
  output logic [DW-1:0] sum_o,
  output flags_t        flags_o
);
  localparam int unsigned NIB = 4;

  logic [DW:0]   diff;
  logic [DW-1:0] sum;

  assign diff  = {1'b0, acc_i} - {1'b0, opnd_i};
  assign sum   = opnd_i + 1'b1;
  assign sum_o = sum;

  always_comb begin
    if (is_cp_i) begin
      flags_o.z = (diff[DW-1:0] == '0);
      flags_o.n = 1'b1;
      flags_o.h = (acc_i[NIB-1:0] < opnd_i[NIB-1:0]);
      flags_o.c = diff[DW];
    end else begin
      flags_o.z = (sum == '0);
      flags_o.n = 1'b0;
      flags_o.h = (opnd_i[NIB-1:0] == {NIB{1'b1}});
      flags_o.c = flags_i.c;
    end
  end
endmodule

// File: rtl/cpinc_regfile.sv
module cpinc_regfile
  import cpinc_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned NREG = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_en_i,
  input  logic [2:0]           ld_sel_i,
  input  logic [DW-1:0]        ld_data_i,
  input  logic                 wr_en_i,
  input  logic [2:0]           wr_sel_i,
  input  logic [DW-1:0]        wr_data_i,
  input  logic                 fl_en_i,
  input  flags_t               fl_d_i,
  output logic [NREG*DW-1:0]   regs_o,
  output flags_t               flags_o
);
  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    if (gi == int'(SEL_MEM)) begin : g_hole
      assign regs_o[gi*DW +: DW] = '0;
    end else begin : g_store
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (wr_en_i && int'(wr_sel_i) == gi) q <= wr_data_i;
        else if (ld_en_i && int'(ld_sel_i) == gi) q <= ld_data_i;
      end
      assign regs_o[gi*DW +: DW] = q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_o <= '0;
    else if (fl_en_i) flags_o <= fl_d_i;
  end
endmodule

// File: rtl/cpinc_unit.sv
module cpinc_unit
  import cpinc_pkg::*;
#(
  parameter int unsigned DW         = 8,
  parameter int unsigned CYC_REG    = 4,
  parameter int unsigned CYC_MEMCMP = 8,
  parameter int unsigned CYC_RMW    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [7:0]        opcode_i,
  input  logic [DW-1:0]     imm_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              illegal_o,
  input  logic              ld_en_i,
  input  logic [2:0]        ld_sel_i,
  input  logic [DW-1:0]     ld_data_i,
  output logic [8*DW-1:0]   regs_o,
  output logic [3:0]        flags_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [2*DW-1:0]   mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [DW-1:0]     mem_rdata_i
);
  localparam int unsigned NREG  = 8;
  localparam int unsigned CNT_W = $clog2(CYC_RMW + 1);

  dec_t             dec;
  flags_t           flags_q, flags_nx;
  logic             busy_q, is_cp_q, illegal_q;
  src_t             src_q;
  logic [2:0]       sel_q;
  phase_t           phase_q;
  logic [CNT_W-1:0] cnt_q, cost_m1;
  logic [DW-1:0]    opnd_q, opnd, acc, sel_val, sum;
  logic             accept, stall, done;

  cpinc_decode u_dec (.op_i(opcode_i), .dec_o(dec));

  always_comb begin
    unique case (dec.cost)
      COST_TWO:   cost_m1 = CNT_W'(CYC_MEMCMP - 1);
      COST_THREE: cost_m1 = CNT_W'(CYC_RMW - 1);
      default:    cost_m1 = CNT_W'(CYC_REG - 1);
    endcase
  end

  assign accept  = start_i && !busy_q;
  assign acc     = regs_o[int'(SEL_A)*DW +: DW];
  assign sel_val = regs_o[int'(sel_q)*DW +: DW];
  assign opnd    = (src_q == SRC_REG) ? sel_val : opnd_q;

  assign mem_req_o   = busy_q && (phase_q != PH_NONE);
  assign mem_we_o    = (phase_q == PH_WR);
  assign mem_addr_o  = {regs_o[int'(SEL_H)*DW +: DW], regs_o[int'(SEL_L)*DW +: DW]};
  assign mem_wdata_o = sum;
  assign stall       = mem_req_o && !mem_ready_i;
  assign done        = busy_q && (cnt_q == '0) && (phase_q == PH_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      is_cp_q   <= 1'b0;
      illegal_q <= 1'b0;
      src_q     <= SRC_REG;
      sel_q     <= '0;
      phase_q   <= PH_NONE;
      cnt_q     <= '0;
      opnd_q    <= '0;
    end else begin
      illegal_q <= accept && !dec.legal;
      if (accept && dec.legal) begin
        busy_q  <= 1'b1;
        is_cp_q <= dec.is_cp;
        src_q   <= dec.src;
        sel_q   <= dec.sel;
        cnt_q   <= cost_m1;
        phase_q <= (dec.src == SRC_MEM) ? PH_RD : PH_NONE;
        opnd_q  <= imm_i;
      end else if (busy_q) begin
        if (!stall && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        if (phase_q == PH_RD && mem_ready_i) begin
          opnd_q  <= mem_rdata_i;
          phase_q <= is_cp_q ? PH_NONE : PH_WR;
        end else if (phase_q == PH_WR && mem_ready_i) begin
          phase_q <= PH_NONE;
        end
        if (done) busy_q <= 1'b0;
      end
    end
  end

  cpinc_alu #(.DW(DW)) u_alu (
    .is_cp_i (is_cp_q),
    .acc_i   (acc),
    .opnd_i  (opnd),
    .flags_i (flags_q),
    .sum_o   (sum),
    .flags_o (flags_nx)
  );

  cpinc_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_en_i   (ld_en_i && !busy_q),
    .ld_sel_i  (ld_sel_i),
    .ld_data_i (ld_data_i),
    .wr_en_i   (done && !is_cp_q && src_q == SRC_REG),
    .wr_sel_i  (sel_q),
    .wr_data_i (sum),
    .fl_en_i   (done),
    .fl_d_i    (flags_nx),
    .regs_o    (regs_o),
    .flags_o   (flags_q)
  );

  assign flags_o   = flags_q;
  assign busy_o    = busy_q;
  assign done_o    = done;
  assign illegal_o = illegal_q;

  a_r1_cp_keeps_a: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && is_cp_q |=> $stable(regs_o[int'(SEL_A)*DW +: DW]));
  a_r5_inc_keeps_c: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !is_cp_q |=> $stable(flags_o[0]));
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r7_cp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_we_o |-> !is_cp_q);
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable({mem_addr_o, mem_we_o, mem_wdata_o}));
  a_r9_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !busy_o && !done_o);
  a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !done_o |=> busy_o);
endmodule

// File: tb/cpinc_unit_tb.sv
`timescale 1ns/1ps
module cpinc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  opcode_i = '0;
  logic [7:0]  imm_i = '0;
  logic        busy_o, done_o, illegal_o;
  logic        ld_en_i = 1'b0;
  logic [2:0]  ld_sel_i = '0;
  logic [7:0]  ld_data_i = '0;
  logic [63:0] regs_o;
  logic [3:0]  flags_o;
  logic        mem_req_o, mem_we_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic        mem_ready_i = 1'b0;
  logic [7:0]  mem_rdata_i = '0;

  always #2.5 clk = ~clk;

  cpinc_unit dut_i (.*);

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] mref [0:7];
  logic [3:0] fref = '0;
  logic [7:0] mem_byte = '0, wr_data = '0;
  bit stall_en = 0;
  int stall_cnt = 0, rd_cnt = 0, wr_cnt = 0, addr_err = 0, order_err = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int cost_of(input logic [7:0] op);
    if (op == 8'h34) return 12;
    if (op == 8'hBE || op == 8'hFE) return 8;
    return 4;
  endfunction

  function automatic logic [3:0] cp_flags(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] d = a - b;
    return {d == 8'h00, 1'b1, a[3:0] < b[3:0], a < b};
  endfunction

  function automatic logic [7:0] pick_op(input int k);
    if (k < 8) return 8'hB8 + 8'(k);
    if (k == 8) return 8'hFE;
    return 8'h04 + 8'((k - 9) * 8);
  endfunction

  // memory responder with optional back-pressure
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_o) begin
        mem_ready_i = !stall_en || ($urandom % 3 != 0);
        mem_rdata_i = mem_byte;
        if (!mem_ready_i) stall_cnt++;
        else begin
          if (mem_addr_o != {mref[4], mref[5]}) addr_err++;
          if (mem_we_o) begin
            wr_cnt++;
            wr_data = mem_wdata_o;
            if (rd_cnt == 0) order_err++;
          end else rd_cnt++;
        end
      end else mem_ready_i = 1'b0;
    end
  end

  task automatic check_regs(input string tag);
    bit ok = 1;
    int bad = 0;
    for (int i = 0; i < 8; i++) begin
      if (i != 6 && regs_o[i*8 +: 8] !== mref[i]) begin ok = 0; bad = i; end
    end
    chk(ok && regs_o[55:48] == 8'h00, tag, regs_o[bad*8 +: 8], mref[bad]);
    chk(flags_o === fref, {tag, " flags"}, flags_o, fref);
  endtask

  task automatic load(input logic [2:0] sel, input logic [7:0] v);
    @(negedge clk);
    ld_en_i = 1; ld_sel_i = sel; ld_data_i = v;
    @(negedge clk);
    ld_en_i = 0;
    if (sel != 3'd6) mref[sel] = v;
  endtask

  task automatic run_op(input logic [7:0] op, input logic [7:0] imm, input bit stl, input bit poke);
    int n;
    int exp_cyc;
    logic [7:0] opnd, res;
    bit is_cp, is_mem;
    stall_en = stl; stall_cnt = 0; rd_cnt = 0; wr_cnt = 0; addr_err = 0; order_err = 0;
    is_cp = (op[7:3] == 5'b10111) || op == 8'hFE;
    is_mem = is_cp ? (op == 8'hBE) : (op == 8'h34);
    if (op == 8'hFE) opnd = imm;
    else if (is_mem) opnd = mem_byte;
    else opnd = is_cp ? mref[op[2:0]] : mref[op[5:3]];
    @(negedge clk);
    start_i = 1; opcode_i = op; imm_i = imm;
    @(negedge clk);
    start_i = 0; opcode_i = 8'h00; imm_i = ~imm;
    n = 1;
    while (!done_o && n < 80) begin
      start_i = poke && (n == 2);
      opcode_i = 8'h3C;
      @(negedge clk);
      n++;
    end
    start_i = 0;
    exp_cyc = cost_of(op) + stall_cnt;
    chk(n == exp_cyc, $sformatf("R6/R8 cycles op=%02h", op), n, exp_cyc);
    if (is_cp) begin
      fref = cp_flags(mref[7], opnd);
    end else begin
      res = opnd + 8'd1;
      fref = {res == 8'h00, 1'b0, opnd[3:0] == 4'hF, fref[0]};
      if (is_mem) begin
        chk(wr_cnt == 1 && wr_data == res && order_err == 0,
            "R7 write-back", wr_data, res);
        mem_byte = res;
      end else mref[op[5:3]] = res;
    end
    chk(rd_cnt == (is_mem ? 1 : 0) && addr_err == 0 && (is_cp || is_mem || wr_cnt == 0),
        "R7 memory traffic", rd_cnt, is_mem);
    @(negedge clk);
    check_regs($sformatf("R1/R2/R3/R4/R5 result op=%02h", op));
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mref[i] = '0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && mem_req_o == 0 && done_o == 0, "R11 idle after reset", busy_o, 0);
    check_regs("R11 reset registers");
    rst_n = 1;
    // R12 load and ignored code 6
    load(3'd7, 8'h42); load(3'd6, 8'hAA); load(3'd0, 8'h0F);
    check_regs("R12 load port");
    // R5 R4 nibble boundary 0x0F and wrap 0xFF
    run_op(8'h04, 8'h00, 0, 0);
    load(3'd1, 8'hFF);
    run_op(8'h0C, 8'h00, 0, 0);
    chk(fref == 4'b1010, "R5 wrap flags", fref, 4'b1010);
    // R2 compare equal, less, greater, self, half borrow
    run_op(8'hFE, 8'h42, 0, 0);
    run_op(8'hFE, 8'h50, 0, 0);
    run_op(8'hFE, 8'h03, 0, 0);
    run_op(8'hBF, 8'h00, 0, 0);
    chk(flags_o == 4'b1100, "R2 self compare", flags_o, 4'b1100);
    load(3'd2, 8'h01); load(3'd7, 8'h10);
    run_op(8'hBA, 8'h00, 0, 0);
    // R5 carry kept after compare set C
    run_op(8'hFE, 8'hF0, 0, 0);
    run_op(8'h3C, 8'h00, 0, 0);
    // R7 memory forms
    load(3'd4, 8'h12); load(3'd5, 8'h34); mem_byte = 8'hFF;
    run_op(8'h34, 8'h00, 0, 0);
    mem_byte = 8'h0F;
    run_op(8'h34, 8'h00, 1, 0);
    run_op(8'hBE, 8'h00, 1, 0);
    // R10 start while busy
    run_op(8'h14, 8'h00, 0, 1);
    run_op(8'h34, 8'h00, 0, 1);
    // R9 illegal opcode
    @(negedge clk); start_i = 1; opcode_i = 8'h00;
    @(negedge clk); start_i = 0;
    chk(illegal_o == 1 && busy_o == 0, "R9 illegal pulse", illegal_o, 1);
    @(negedge clk);
    chk(illegal_o == 0 && done_o == 0, "R9 illegal single", illegal_o, 0);
    check_regs("R9 no state change");
    // random mix of all legal opcodes
    for (int t = 0; t < 400; t++) begin
      if (t % 8 == 0) begin
        for (int r = 0; r < 8; r++) load(3'(r), 8'($urandom));
        mem_byte = 8'($urandom);
      end
      run_op(pick_op($urandom % 17), 8'($urandom), ($urandom % 2) == 1, ($urandom % 4) == 0);
    end
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule